// File: doc/BRIEF.md
# Self-Centring Input Delay Calibrator

This block places the capture point of a source-synchronous input bus in the middle of its data valid window. The forwarded bus clock runs through its own adjustable monitor delay, which is kept apart from the data delays. A capture flop samples that delayed clock, and the sampled bit is the only measurement the block receives. The block steps the monitor tap upward from zero. At each tap it waits for the delay to settle and then reads the bit several times. It takes the tap where the majority level first changes as the lower edge and the tap where it changes a second time as the upper edge.

When both edges are known, the block rounds their midpoint down and drives that one tap value to the delay control shared by every data bit. The monitor delay can move freely during a sweep because the shared data tap changes only at the commit. One start pulse runs a single calibration. With continuous mode held high, the block sweeps again after every result, so the centre follows drift in temperature and supply voltage. Each tap is a fine equal step of nominally 75 ps. The block does not remove skew between data lines, or between data and clock.

Top module: `tapcal_top`

## Requirements
- R1: During and after reset, `dataTap` is 32, `monTap` is 0 and `calDone` and `calError` are 0.
- R2: A sweep starts at monitor tap 0 and raises `monTap` by exactly one per step. Consecutive steps are `S + 9` cycles apart, where S is `settleCycles` raised to at least 4. That is S settle cycles, 8 sample cycles and 1 decision cycle.
- R3: Each tap's level is the majority of 8 samples of `monBit`: high when more than 4 samples are 1. Up to 2 disagreeing samples at a tap neither create nor hide a transition.
- R4: Tap 0 only sets the reference level. A transition is a tap whose majority level differs from the previous tap's level, in either direction. The first transition gives edge1 and the second gives edge2.
- R5: On the second transition, `dataTap` becomes floor((edge1 + edge2) / 2). On that same clock edge `calDone` goes high for exactly one cycle.
- R6: `dataTap` changes only on the edge where `calDone` rises. Monitor tap movement never changes it.
- R7: If tap 63 is judged and two transitions have not been found, `calError` is high for one cycle. `dataTap` keeps its previous value, and `calDone` and `calError` are never high together.
- R8: With `contMode` low, a one-cycle `startPulse` runs exactly one calibration. After that result, no further `calDone` or `calError` appears until the next start.
- R9: With `contMode` high, a new sweep begins the cycle after each result. A later result follows a window that has moved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts one calibration while idle |
| contMode | input | 1 | Repeat calibration continuously while high |
| settleCycles | input | 8 | Settle wait after each tap change; values under 4 act as 4 |
| monBit | input | 1 | Sampled output of the monitor capture flop |
| monTap | output | 6 | Tap value for the monitor delay |
| dataTap | output | 6 | Common tap value for all data-bit delays |
| calDone | output | 1 | One-cycle pulse when a new centre is committed |
| calError | output | 1 | One-cycle pulse when a sweep ends without two edges |

## Verification
A wrong edge register or a wrong stored reference level shows up as a wrong `dataTap` on the very edge where `calDone` pulses, so each calibration is checked once, at that edge. A wrong step or settle count shows on `monTap` within one step interval, because the spacing between tap changes is measured in cycles. A lost edge count shows up as `calError` in place of `calDone`, about 64 step intervals after the start. A stray write to the shared tap is caught in the cycle it happens by watching `dataTap` against `calDone` all the time.

// File: rtl/tapcal_pkg.sv
package tapcal_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clrSweep;     // monitor tap to 0, clear edges
    logic runSettle;    // count settle cycles, clear sample accumulators
    logic takeSample;   // accumulate one monitor sample
    logic stepTap;      // advance monitor tap by one
    logic recordLevel;  // store current majority as reference level
    logic storeEdge1;   // capture current tap as lower edge
    logic commit;       // capture upper edge and write the centre
  } dpCtrl_t;

  // flags from datapath to control
  typedef struct packed {
    logic settleDone;
    logic samplesDone;
    logic levelChanged;
    logic tapAtMax;
  } dpStat_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SAMPLE,
    ST_JUDGE
  } calState_t;

endpackage

// File: rtl/tapcal_datapath.sv
module tapcal_datapath
  import tapcal_pkg::*;
#(
  parameter int TAP_W      = 6,
  parameter int SETTLE_W   = 8,
  parameter int SAMPLES    = 8,
  parameter int MIN_SETTLE = 4,
  parameter int RESET_TAP  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                monBit,
  input  dpCtrl_t             ctl,
  output dpStat_t             stat,
  output logic [TAP_W-1:0]    monTap,
  output logic [TAP_W-1:0]    dataTap
);

  localparam int CNT_W = $clog2(SAMPLES + 1);
  localparam logic [TAP_W-1:0]    TAP_MAX   = '1;
  localparam logic [CNT_W-1:0]    LAST_SMP  = CNT_W'(SAMPLES - 1);
  localparam logic [CNT_W-1:0]    HALF_SMP  = CNT_W'(SAMPLES / 2);
  localparam logic [SETTLE_W-1:0] MIN_SET   = SETTLE_W'(MIN_SETTLE);
  localparam logic [TAP_W-1:0]    RST_TAP   = TAP_W'(RESET_TAP);

  logic [TAP_W-1:0]    monTapQ, dataTapQ, edge1Q, edge2Q;
  logic                prevLevelQ;
  logic [CNT_W-1:0]    onesQ, sampleCntQ;
  logic [SETTLE_W-1:0] settleCntQ;
  logic [SETTLE_W-1:0] effSettle;
  logic [TAP_W:0]      edgeSum;
  logic [TAP_W-1:0]    centreTap;
  logic                majority;

  assign effSettle = (settleCycles < MIN_SET) ? MIN_SET : settleCycles;
  assign majority  = (onesQ > HALF_SMP);
  assign edgeSum   = {1'b0, edge1Q} + {1'b0, monTapQ};
  assign centreTap = edgeSum[TAP_W:1];

  // settle counter and sample accumulators
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settleCntQ <= '0;
      sampleCntQ <= '0;
      onesQ      <= '0;
    end else if (ctl.runSettle) begin
      settleCntQ <= settleCntQ + 1'b1;
      sampleCntQ <= '0;
      onesQ      <= '0;
    end else begin
      settleCntQ <= '0;
      if (ctl.takeSample) begin
        sampleCntQ <= sampleCntQ + 1'b1;
        onesQ      <= onesQ + CNT_W'(monBit);
      end
    end
  end

  // monitor tap stepping
  always_ff @(posedge clk) begin
    if (!rst_n)             monTapQ <= '0;
    else if (ctl.clrSweep)  monTapQ <= '0;
    else if (ctl.stepTap)   monTapQ <= monTapQ + 1'b1;
  end

  // reference level and edges
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevLevelQ <= 1'b0;
      edge1Q     <= '0;
      edge2Q     <= '0;
    end else if (ctl.clrSweep) begin
      prevLevelQ <= 1'b0;
      edge1Q     <= '0;
      edge2Q     <= '0;
    end else begin
      if (ctl.recordLevel) prevLevelQ <= majority;
      if (ctl.storeEdge1)  edge1Q     <= monTapQ;
      if (ctl.commit)      edge2Q     <= monTapQ;
    end
  end

  // shared data tap, written only by a commit
  always_ff @(posedge clk) begin
    if (!rst_n)          dataTapQ <= RST_TAP;
    else if (ctl.commit) dataTapQ <= centreTap;
  end

  assign stat.settleDone   = (settleCntQ == effSettle - 1'b1);
  assign stat.samplesDone  = (sampleCntQ == LAST_SMP);
  assign stat.levelChanged = (majority != prevLevelQ);
  assign stat.tapAtMax     = (monTapQ == TAP_MAX);

  assign monTap  = monTapQ;
  assign dataTap = dataTapQ;

  AST_DATA_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.commit |=> $stable(dataTapQ)); // R6

  AST_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(monTapQ) |-> (monTapQ == '0 || monTapQ == $past(monTapQ) + 1'b1)); // R2

  AST_CENTRE_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.commit |=> (dataTapQ >= edge1Q && dataTapQ <= edge2Q)); // R5

  AST_EDGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.commit |-> (monTapQ > edge1Q)); // R4

endmodule

// File: rtl/tapcal_control.sv
module tapcal_control
  import tapcal_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    startPulse,
  input  logic    contMode,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    calDone,
  output logic    calError
);

  calState_t stateQ, stateD;
  logic firstTapQ, firstTapD;
  logic edgeSeenQ, edgeSeenD;
  logic doneQ, errQ, doneD, errD;

  always_comb begin
    stateD    = stateQ;
    firstTapD = firstTapQ;
    edgeSeenD = edgeSeenQ;
    doneD     = 1'b0;
    errD      = 1'b0;
    ctl       = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startPulse || contMode) begin
          ctl.clrSweep = 1'b1;
          firstTapD    = 1'b1;
          edgeSeenD    = 1'b0;
          stateD       = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        ctl.runSettle = 1'b1;
        if (stat.settleDone) stateD = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        ctl.takeSample = 1'b1;
        if (stat.samplesDone) stateD = ST_JUDGE;
      end
      ST_JUDGE: begin
        stateD = ST_SETTLE;
        if (firstTapQ) begin
          ctl.recordLevel = 1'b1;
          firstTapD       = 1'b0;
        end else if (stat.levelChanged) begin
          ctl.recordLevel = 1'b1;
          if (!edgeSeenQ) begin
            ctl.storeEdge1 = 1'b1;
            edgeSeenD      = 1'b1;
          end else begin
            ctl.commit = 1'b1;
            doneD      = 1'b1;
            stateD     = ST_IDLE;
          end
        end
        if (!ctl.commit) begin
          if (stat.tapAtMax) begin
            errD   = 1'b1;
            stateD = ST_IDLE;
          end else begin
            ctl.stepTap = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ    <= ST_IDLE;
      firstTapQ <= 1'b0;
      edgeSeenQ <= 1'b0;
      doneQ     <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      stateQ    <= stateD;
      firstTapQ <= firstTapD;
      edgeSeenQ <= edgeSeenD;
      doneQ     <= doneD;
      errQ      <= errD;
    end
  end

  assign calDone  = doneQ;
  assign calError = errQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    calDone |=> !calDone); // R5

  AST_ERROR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    calError |=> !calError); // R7

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(calDone && calError)); // R7

  AST_ERROR_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(calError) |-> $past(stat.tapAtMax)); // R7

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.clrSweep, ctl.runSettle, ctl.takeSample, ctl.stepTap, ctl.commit})); // R2

endmodule

// File: rtl/tapcal_top.sv
module tapcal_top
  import tapcal_pkg::*;
#(
  parameter int TAP_W      = 6,
  parameter int SETTLE_W   = 8,
  parameter int SAMPLES    = 8,
  parameter int MIN_SETTLE = 4,
  parameter int RESET_TAP  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startPulse,
  input  logic                contMode,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic                monBit,
  output logic [TAP_W-1:0]    monTap,
  output logic [TAP_W-1:0]    dataTap,
  output logic                calDone,
  output logic                calError
);

  dpCtrl_t ctl;
  dpStat_t stat;

  tapcal_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .contMode   (contMode),
    .stat       (stat),
    .ctl        (ctl),
    .calDone    (calDone),
    .calError   (calError)
  );

  tapcal_datapath #(
    .TAP_W      (TAP_W),
    .SETTLE_W   (SETTLE_W),
    .SAMPLES    (SAMPLES),
    .MIN_SETTLE (MIN_SETTLE),
    .RESET_TAP  (RESET_TAP)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .settleCycles (settleCycles),
    .monBit       (monBit),
    .ctl          (ctl),
    .stat         (stat),
    .monTap       (monTap),
    .dataTap      (dataTap)
  );

endmodule

// File: tb/tapcal_top_test.sv
module tapcal_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       startPulse = 1'b0;
  logic       contMode = 1'b0;
  logic [7:0] settleCycles = 8'd4;
  logic       monBit = 1'b0;
  logic [5:0] monTap, dataTap;
  logic       calDone, calError;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int holdBad = 0;
  logic [5:0] prevTap = 6'd32;

  int winLo = 0, winHi = 0;
  logic winInv = 1'b0, winNoise = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  tapcal_top uut (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .contMode(contMode),
    .settleCycles(settleCycles), .monBit(monBit), .monTap(monTap),
    .dataTap(dataTap), .calDone(calDone), .calError(calError)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // capture-flop model: high inside [winLo, winHi), optional inversion and jitter
  always @(negedge clk) begin
    logic inWin;
    inWin  = (int'(monTap) >= winLo) && (int'(monTap) < winHi);
    monBit <= winInv ^ inWin ^ (winNoise && (cyc % 4 == 0));
  end

  // R6 monitor: dataTap may change only together with calDone
  always @(negedge clk) begin
    if (rst_n && dataTap != prevTap && !calDone) holdBad++;
    prevTap <= dataTap;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startPulse = 1'b1;
    @(negedge clk) startPulse = 1'b0;
  endtask

  task automatic waitResult(output bit gotDone, output bit gotErr);
    gotDone = 0; gotErr = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (calDone || calError) begin
        gotDone = calDone; gotErr = calError;
        break;
      end
    end
  endtask

  localparam int NV = 7;
  localparam int V_LO [NV]  = '{10,  7,  1, 30,  0, 50,  5};
  localparam int V_HI [NV]  = '{20, 12, 63, 31, 40, 64, 40};
  localparam bit V_INV[NV]  = '{ 0,  0,  1,  0,  0,  1,  0};
  localparam bit V_NZ [NV]  = '{ 0,  1,  0,  0,  0,  0,  1};
  localparam bit V_OK [NV]  = '{ 1,  1,  1,  1,  0,  0,  1};

  initial begin : watchdog
    #1200000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit d, e;
    int lastGood, t1, t2;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(dataTap == 6'd32, "R1 dataTap", dataTap, 32);
    check(monTap == 6'd0, "R1 monTap", monTap, 0);
    check(!calDone && !calError, "R1 flags", {calDone, calError}, 0);
    rst_n = 1'b1;
    lastGood = 32;

    // table-driven calibrations (R3 noise, R4 inverted levels, R5 centre, R7 errors)
    for (int v = 0; v < NV; v++) begin
      int expTap;
      winLo = V_LO[v]; winHi = V_HI[v]; winInv = V_INV[v]; winNoise = V_NZ[v];
      expTap = V_OK[v] ? (V_LO[v] + V_HI[v]) / 2 : lastGood;
      pulseStart();
      waitResult(d, e);
      if (V_OK[v]) begin
        check(d && !e, "R5 done pulse", {d, e}, 2);
        check(int'(dataTap) == expTap, V_NZ[v] ? "R3/R5 centre with jitter" :
              (V_INV[v] ? "R4/R5 centre inverted" : "R5 centre"), dataTap, expTap);
        lastGood = expTap;
      end else begin
        check(e && !d, "R7 error pulse", {d, e}, 1);
        check(int'(dataTap) == expTap, "R7 dataTap kept", dataTap, expTap);
      end
      @(negedge clk);
      check(!calDone && !calError, "R5/R7 single-cycle flag", {calDone, calError}, 0);
    end

    // R2 step spacing with minimum settle and a larger settle
    for (int s = 0; s < 2; s++) begin
      int expGap;
      settleCycles = (s == 0) ? 8'd0 : 8'd10;
      expGap = (s == 0) ? 13 : 19;
      winLo = 10; winHi = 20; winInv = 0; winNoise = 0;
      pulseStart();
      check(monTap == 6'd0, "R2 sweep starts at 0", monTap, 0);
      while (monTap != 6'd1) @(negedge clk);
      t1 = cyc;
      while (monTap != 6'd2) @(negedge clk);
      t2 = cyc;
      check(t2 - t1 == expGap, "R2 step spacing", t2 - t1, expGap);
      waitResult(d, e);
      check(d && dataTap == 6'd15, "R2 sweep result", dataTap, 15);
    end
    settleCycles = 8'd4;

    // R8 single shot: nothing follows
    d = 0; e = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (calDone) d = 1;
      if (calError) e = 1;
    end
    check(!d && !e, "R8 no activity after single run", {d, e}, 0);
    check(dataTap == 6'd15, "R8 dataTap unchanged while idle", dataTap, 15);

    // R9 continuous tracking
    winLo = 20; winHi = 30;
    @(negedge clk) contMode = 1'b1;
    waitResult(d, e);
    check(d && dataTap == 6'd25, "R9 first continuous result", dataTap, 25);
    winLo = 14; winHi = 30;
    waitResult(d, e);
    check(d && dataTap == 6'd22, "R9 tracks moved window", dataTap, 22);
    @(negedge clk) contMode = 1'b0;
    waitResult(d, e);
    d = 0; e = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (calDone || calError) d = 1;
    end
    check(!d, "R8 stops when continuous mode drops", d, 0);

    check(holdBad == 0, "R6 dataTap moved without commit", holdBad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule